// File: doc/BRIEF.md
# Command Packet Header Decoder

This block reads 32-bit words from a command stream and turns each packet into write transactions. A packet starts with a header word whose low three bits give the packet type. The decoder emits register writes to a 3D or 2D register set, bulk writes to frame buffer or texture memory, and jump requests that tell the stream tracker where to continue reading. Headers it cannot handle raise a one-cycle error pulse and are skipped.

Words arrive on a valid input. The decoder takes a word in every cycle that `in_valid` is high, and marks each word it takes with `in_pop`. Every transaction is registered, so it appears on the output ports in the cycle after the clock edge that took the word which caused it.

The controller has six states:
- `S_HDR` waits for a header and decodes it.
- `S_REGRUN` handles a sequential register run.
- `S_MASKRUN` handles a masked register write.
- `S_PAD` discards pad words.
- `S_MEMADDR` takes the address word of a memory packet.
- `S_MEMRUN` handles the data words of a memory packet.

Transitions:
- `S_HDR` goes to `S_REGRUN` on a type-1 header with a nonzero count.
- `S_HDR` goes to `S_MASKRUN` on a type-4 header with a nonzero mask.
- `S_HDR` goes to `S_PAD` on a type-4 header with a zero mask and nonzero pad.
- `S_HDR` goes to `S_MEMADDR` on any type-5 header.
- `S_REGRUN` and `S_MEMRUN` return to `S_HDR` when they take their last word.
- `S_MASKRUN` goes to `S_PAD` or `S_HDR` when it takes the word for the last set mask bit.
- `S_PAD` returns to `S_HDR` when it takes its last pad word.
- `S_MEMADDR` goes to `S_MEMRUN`, or to `S_HDR` if the count is zero.
- Every other header leaves the controller in `S_HDR`.

Top module: `cmd_packet_decoder`

## Requirements
- R1: `in_pop` is high exactly in the cycles where `in_valid` is high and reset is released, and each such cycle consumes one word. While `in_valid` is low, the decoder state does not change.
- R2: A type-0 header with subcode 0 (bits 5:3) produces no output. A type-0 header with subcode 3 produces a one-cycle jump with pointer `(header >> 4) & 0xFFFFFC`.
- R3: A type-1 header has a count in bits 31:16, a start register address in bits 14:3 and an increment flag in bit 15. It writes the next `count` words to registers, one per word. The address goes up by one after each word only if the flag is set. A count of 0 consumes only the header.
- R4: A register address has 12 bits. Bit 11 drives `reg_2d` (1 selects the 2D set), and bits 10:0 drive `reg_addr`.
- R5: A type-4 header has a mask in bits 28:15 and a base address in bits 14:3. It takes one data word per set mask bit, lowest bit first. Each word goes to the base address plus that bit's index.
- R6: After its data words, a type-4 packet consumes the number of pad words given in header bits 31:29, with no output. A zero mask consumes only the pad words.
- R7: A type-5 header has a count in bits 21:3 and a target code in bits 31:30. The next word gives the word address `(w & 0xFFFFFF) >> 2`. Then `count` data words are written at consecutive addresses. Code 2 targets the frame buffer (`mem_tex`=0) and code 3 targets texture memory (`mem_tex`=1).
- R8: A type-5 header raises `err` for one cycle if any of bits 29:22 is nonzero or if the code is 0 or 1. Its address word and data words are still consumed, but no write is made.
- R9: Headers of type 2, 3, 6 or 7, and type-0 headers with a subcode other than 0 or 3, raise `err` for one cycle and consume only the header. The next word is treated as a header.
- R10: Every output event appears in the cycle after the edge that took its word. At most one of `reg_we`, `mem_we`, `jmp_valid` and `err` is high in any cycle. During reset all of them are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_word | input | 32 | Command stream word |
| in_valid | input | 1 | `in_word` holds a word |
| in_pop | output | 1 | The word is consumed at this edge |
| reg_we | output | 1 | Register write strobe |
| reg_2d | output | 1 | 1 selects the 2D register set, 0 the 3D set |
| reg_addr | output | 11 | Register index within the selected set |
| reg_data | output | 32 | Register write data |
| mem_we | output | 1 | Memory write strobe |
| mem_tex | output | 1 | 1 targets texture memory, 0 the frame buffer |
| mem_addr | output | 22 | Memory word address |
| mem_data | output | 32 | Memory write data |
| jmp_valid | output | 1 | Jump request strobe |
| jmp_ptr | output | 24 | New read pointer (byte address) |
| err | output | 1 | Unsupported packet pulse |

## Verification
The hardest cases to reach are the boundaries inside a packet:
- a masked write whose address crosses from the 3D into the 2D set partway through its mask;
- pad words that happen to look like valid headers;
- dropped memory packets that must still consume their address and data words.

The stimulus builds these packets field by field. Pad and dropped words are chosen to decode as jumps or writes if they were misread. Each odd packet is followed by a jump header, so a decoder that loses its place shows up as a missing or extra event. Idle gaps are inserted in the middle of packets to exercise stalls in every data state.

// File: rtl/cpd_pkg.sv
package cpd_pkg;

    localparam int WORD_W    = 32;
    localparam int TYPE_W    = 3;
    localparam int SUB_W     = 3;
    localparam int REG_AW    = 12;
    localparam int REG_LOW_W = REG_AW - 1;
    localparam int MASK_W    = 14;
    localparam int PAD_W     = 3;
    localparam int CNT1_W    = 16;
    localparam int CNT5_W    = 19;
    localparam int CNT_W     = (CNT5_W > CNT1_W) ? CNT5_W : CNT1_W;
    localparam int MEM_AW    = 22;
    localparam int PTR_W     = 24;
    localparam int CODE_W    = 2;
    localparam int IDX_W     = $clog2(MASK_W);

    localparam logic [TYPE_W-1:0] TYP_CTL  = 3'd0;
    localparam logic [TYPE_W-1:0] TYP_RUN  = 3'd1;
    localparam logic [TYPE_W-1:0] TYP_MASK = 3'd4;
    localparam logic [TYPE_W-1:0] TYP_MEM  = 3'd5;

    localparam logic [SUB_W-1:0]  SUB_NOP  = 3'd0;
    localparam logic [SUB_W-1:0]  SUB_JMP  = 3'd3;

    typedef enum logic [2:0] {
        S_HDR,
        S_REGRUN,
        S_MASKRUN,
        S_PAD,
        S_MEMADDR,
        S_MEMRUN
    } state_t;

    typedef struct packed {
        logic [TYPE_W-1:0] typ;
        logic [SUB_W-1:0]  sub;
        logic [PTR_W-1:0]  jptr;
        logic [CNT1_W-1:0] run_cnt;
        logic              run_inc;
        logic [REG_AW-1:0] raddr;
        logic [MASK_W-1:0] mask;
        logic [PAD_W-1:0]  pad;
        logic [CNT5_W-1:0] mem_cnt;
        logic [CODE_W-1:0] mem_code;
        logic              mem_bd;
    } hdr_t;

endpackage

// File: rtl/cpd_hdr_decode.sv
module cpd_hdr_decode
    import cpd_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output hdr_t              hdr
);

    always_comb begin
        hdr.typ      = word[2:0];
        hdr.sub      = word[5:3];
        hdr.jptr     = {word[27:6], 2'b00};
        hdr.run_cnt  = word[31:16];
        hdr.run_inc  = word[15];
        hdr.raddr    = word[14:3];
        hdr.mask     = word[28:15];
        hdr.pad      = word[31:29];
        hdr.mem_cnt  = word[21:3];
        hdr.mem_code = word[31:30];
        hdr.mem_bd   = |word[29:22];
    end

endmodule

// File: rtl/cpd_mask_walk.sv
module cpd_mask_walk #(
    parameter int W  = 14,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  mask,
    output logic          any,
    output logic [IW-1:0] idx,
    output logic [W-1:0]  rest
);

    // Lowest set bit wins: scan from the top so the last hit is the lowest.
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (mask[i]) begin
                idx = IW'(i);
            end
        end
        any  = |mask;
        rest = mask & (mask - W'(1));
    end

endmodule

// File: rtl/cmd_packet_decoder.sv
module cmd_packet_decoder
    import cpd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [WORD_W-1:0]    in_word,
    input  logic                 in_valid,
    output logic                 in_pop,
    output logic                 reg_we,
    output logic                 reg_2d,
    output logic [REG_LOW_W-1:0] reg_addr,
    output logic [WORD_W-1:0]    reg_data,
    output logic                 mem_we,
    output logic                 mem_tex,
    output logic [MEM_AW-1:0]    mem_addr,
    output logic [WORD_W-1:0]    mem_data,
    output logic                 jmp_valid,
    output logic [PTR_W-1:0]     jmp_ptr,
    output logic                 err
);

    state_t             state, nxt;
    hdr_t               dec;
    logic [CNT_W-1:0]   cnt_q;
    logic [MEM_AW-1:0]  addr_q;
    logic               inc_q;
    logic [MASK_W-1:0]  mask_q;
    logic [PAD_W-1:0]   pad_q;
    logic               drop_q;
    logic               tex_q;
    logic               walk_any;
    logic [IDX_W-1:0]   walk_idx;
    logic [MASK_W-1:0]  walk_rest;
    logic               mem_drop;
    logic               hdr_err;
    logic [REG_AW-1:0]  mask_addr;

    cpd_hdr_decode u_dec (
        .word (in_word),
        .hdr  (dec)
    );

    cpd_mask_walk #(.W(MASK_W), .IW(IDX_W)) u_walk (
        .mask (mask_q),
        .any  (walk_any),
        .idx  (walk_idx),
        .rest (walk_rest)
    );

    assign in_pop    = in_valid & rst_n;
    assign mem_drop  = dec.mem_bd || (dec.mem_code < CODE_W'(2));
    assign mask_addr = addr_q[REG_AW-1:0] + REG_AW'(walk_idx);

    always_comb begin
        unique case (dec.typ)
            TYP_CTL:          hdr_err = !((dec.sub == SUB_NOP) || (dec.sub == SUB_JMP));
            TYP_RUN, TYP_MASK: hdr_err = 1'b0;
            TYP_MEM:          hdr_err = mem_drop;
            default:          hdr_err = 1'b1;
        endcase
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_HDR: begin
                if (in_valid) begin
                    if (dec.typ == TYP_RUN) begin
                        if (dec.run_cnt != '0) nxt = S_REGRUN;
                    end else if (dec.typ == TYP_MASK) begin
                        if (|dec.mask)           nxt = S_MASKRUN;
                        else if (dec.pad != '0)  nxt = S_PAD;
                    end else if (dec.typ == TYP_MEM) begin
                        nxt = S_MEMADDR;
                    end
                end
            end
            S_REGRUN: begin
                if (in_valid && (cnt_q == CNT_W'(1))) nxt = S_HDR;
            end
            S_MASKRUN: begin
                if (in_valid && (walk_rest == '0)) nxt = (pad_q != '0) ? S_PAD : S_HDR;
            end
            S_PAD: begin
                if (in_valid && (pad_q == PAD_W'(1))) nxt = S_HDR;
            end
            S_MEMADDR: begin
                if (in_valid) nxt = (cnt_q == '0) ? S_HDR : S_MEMRUN;
            end
            S_MEMRUN: begin
                if (in_valid && (cnt_q == CNT_W'(1))) nxt = S_HDR;
            end
            default: nxt = S_HDR;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_HDR;
        else        state <= nxt;
    end

    // Packet context registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            addr_q <= '0;
            inc_q  <= 1'b0;
            mask_q <= '0;
            pad_q  <= '0;
            drop_q <= 1'b0;
            tex_q  <= 1'b0;
        end else if (in_pop) begin
            unique case (state)
                S_HDR: begin
                    cnt_q  <= (dec.typ == TYP_MEM) ? CNT_W'(dec.mem_cnt) : CNT_W'(dec.run_cnt);
                    addr_q <= MEM_AW'(dec.raddr);
                    inc_q  <= dec.run_inc;
                    mask_q <= dec.mask;
                    pad_q  <= dec.pad;
                    drop_q <= mem_drop;
                    tex_q  <= dec.mem_code[0];
                end
                S_REGRUN: begin
                    cnt_q <= cnt_q - CNT_W'(1);
                    if (inc_q) addr_q <= addr_q + MEM_AW'(1);
                end
                S_MASKRUN: mask_q <= walk_rest;
                S_PAD:     pad_q  <= pad_q - PAD_W'(1);
                S_MEMADDR: addr_q <= in_word[23:2];
                S_MEMRUN: begin
                    cnt_q  <= cnt_q - CNT_W'(1);
                    addr_q <= addr_q + MEM_AW'(1);
                end
                default: ;
            endcase
        end
    end

    // Registered output stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_we    <= 1'b0;
            reg_2d    <= 1'b0;
            reg_addr  <= '0;
            reg_data  <= '0;
            mem_we    <= 1'b0;
            mem_tex   <= 1'b0;
            mem_addr  <= '0;
            mem_data  <= '0;
            jmp_valid <= 1'b0;
            jmp_ptr   <= '0;
            err       <= 1'b0;
        end else begin
            reg_we    <= 1'b0;
            mem_we    <= 1'b0;
            jmp_valid <= 1'b0;
            err       <= 1'b0;
            if (in_pop) begin
                unique case (state)
                    S_HDR: begin
                        err <= hdr_err;
                        if ((dec.typ == TYP_CTL) && (dec.sub == SUB_JMP)) begin
                            jmp_valid <= 1'b1;
                            jmp_ptr   <= dec.jptr;
                        end
                    end
                    S_REGRUN: begin
                        reg_we   <= 1'b1;
                        reg_2d   <= addr_q[REG_AW-1];
                        reg_addr <= addr_q[REG_LOW_W-1:0];
                        reg_data <= in_word;
                    end
                    S_MASKRUN: begin
                        reg_we   <= walk_any;
                        reg_2d   <= mask_addr[REG_AW-1];
                        reg_addr <= mask_addr[REG_LOW_W-1:0];
                        reg_data <= in_word;
                    end
                    S_MEMRUN: begin
                        mem_we   <= !drop_q;
                        mem_tex  <= tex_q;
                        mem_addr <= addr_q;
                        mem_data <= in_word;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Assertions
    assert_pop_has_word_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_pop |-> in_valid);

    assert_stall_holds_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (state == $past(state)));

    assert_single_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_we, mem_we, jmp_valid, err}));

    assert_write_after_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we || mem_we || jmp_valid || err) |-> $past(in_pop));

    assert_mask_bit_retired_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_MASKRUN && in_valid) |=>
            ($countones(mask_q) == $countones($past(mask_q)) - 1));

    assert_pad_no_output_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PAD && in_valid) |=> !(reg_we || mem_we || jmp_valid || err));

endmodule

// File: tb/tb_cmd_packet_decoder.sv
module tb_cmd_packet_decoder;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] in_word;
    logic        in_valid;
    logic        in_pop;
    logic        reg_we, reg_2d;
    logic [10:0] reg_addr;
    logic [31:0] reg_data;
    logic        mem_we, mem_tex;
    logic [21:0] mem_addr;
    logic [31:0] mem_data;
    logic        jmp_valid;
    logic [23:0] jmp_ptr;
    logic        err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct packed {
        logic [1:0]  k;
        logic [23:0] a;
        logic [31:0] d;
        logic        f;
    } ev_t;

    ev_t   exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    cmd_packet_decoder dut (
        .clk(clk), .rst_n(rst_n), .in_word(in_word), .in_valid(in_valid), .in_pop(in_pop),
        .reg_we(reg_we), .reg_2d(reg_2d), .reg_addr(reg_addr), .reg_data(reg_data),
        .mem_we(mem_we), .mem_tex(mem_tex), .mem_addr(mem_addr), .mem_data(mem_data),
        .jmp_valid(jmp_valid), .jmp_ptr(jmp_ptr), .err(err)
    );

    function automatic logic [31:0] hdr1(input logic [15:0] cnt, input logic [11:0] a, input logic inc);
        return {cnt, inc, a, 3'd1};
    endfunction
    function automatic logic [31:0] hdr4(input logic [2:0] pad, input logic [13:0] m, input logic [11:0] a);
        return {pad, m, a, 3'd4};
    endfunction
    function automatic logic [31:0] hdr5(input logic [1:0] code, input logic [7:0] bd, input logic [18:0] cnt);
        return {code, bd, cnt, 3'd5};
    endfunction

    task automatic push(input ev_t e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask
    task automatic exp_reg(input logic [11:0] a, input logic [31:0] d, input string t);
        push('{k: 2'd0, a: 24'(a), d: d, f: 1'b0}, t);
    endtask
    task automatic exp_mem(input logic tex, input logic [21:0] a, input logic [31:0] d, input string t);
        push('{k: 2'd1, a: 24'(a), d: d, f: tex}, t);
    endtask
    task automatic exp_jmp(input logic [31:0] hdr, input string t);
        logic [31:0] p;
        p = (hdr >> 4) & 32'h00FF_FFFC;
        push('{k: 2'd2, a: p[23:0], d: 32'd0, f: 1'b0}, t);
    endtask
    task automatic exp_err(input string t);
        push('{k: 2'd3, a: 24'd0, d: 32'd0, f: 1'b0}, t);
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic send(input logic [31:0] w);
        in_valid = 1'b1;
        in_word  = w;
        #1;
        checks++;
        if (in_pop !== 1'b1) begin
            fails++;
            $display("FAIL R1: in_pop actual %b expected 1 with valid word", in_pop);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        #1;
        checks++;
        if (in_pop !== 1'b0) begin
            fails++;
            $display("FAIL R1: in_pop actual %b expected 0 while idle", in_pop);
        end
        @(negedge clk);
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic drained(input string t);
        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL %s: actual %0d events outstanding expected 0", t, exp_q.size());
            exp_q.delete();
            tag_q.delete();
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin : monitor
        int   n;
        ev_t  obs, e;
        string t;
        if (rst_n === 1'b1 && !done) begin
            n = int'(reg_we) + int'(mem_we) + int'(jmp_valid) + int'(err);
            if (n > 1) begin
                checks++;
                fails++;
                $display("FAIL R10: actual %0d simultaneous events expected at most 1", n);
            end else if (n == 1) begin
                if (reg_we)         obs = '{k: 2'd0, a: 24'({reg_2d, reg_addr}), d: reg_data, f: 1'b0};
                else if (mem_we)    obs = '{k: 2'd1, a: 24'(mem_addr), d: mem_data, f: mem_tex};
                else if (jmp_valid) obs = '{k: 2'd2, a: jmp_ptr, d: 32'd0, f: 1'b0};
                else                obs = '{k: 2'd3, a: 24'd0, d: 32'd0, f: 1'b0};
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R10: actual unexpected event k=%0d a=%h d=%h f=%b expected none",
                             obs.k, obs.a, obs.d, obs.f);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (obs !== e) begin
                        fails++;
                        $display("FAIL %s: actual k=%0d a=%h d=%h f=%b expected k=%0d a=%h d=%h f=%b",
                                 t, obs.k, obs.a, obs.d, obs.f, e.k, e.a, e.d, e.f);
                    end
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin : stimulus
        logic [31:0] j;
        rst_n    = 1'b0;
        in_valid = 1'b1;
        in_word  = 32'h0000_0018;
        repeat (3) @(negedge clk);
        checks++;
        if ({in_pop, reg_we, mem_we, jmp_valid, err} !== 5'b0) begin
            fails++;
            $display("FAIL R10: reset outputs actual %b expected 00000",
                     {in_pop, reg_we, mem_we, jmp_valid, err});
        end
        in_valid = 1'b0;
        rst_n    = 1'b1;
        @(negedge clk);

        // R2: no-op, then jump
        send(32'h0000_0000);
        j = 32'h0123_4018;
        exp_jmp(j, "R2");
        send(j);
        j = 32'hFFFF_FF18;
        exp_jmp(j, "R2");
        send(j);
        drained("R2");

        // R9: bad type-0 subcode and unsupported types
        exp_err("R9"); send(32'h0000_0028);
        exp_err("R9"); send(32'h0001_0002);
        exp_err("R9"); send(32'h0000_0003);
        exp_err("R9"); send(32'h0004_0006);
        exp_err("R9"); send(32'hFFFF_FFF7);
        j = 32'h0000_2218;
        exp_jmp(j, "R9");
        send(j);
        drained("R9");

        // R3: incrementing run with a stall in the middle
        send(hdr1(16'd3, 12'h010, 1'b1));
        for (int i = 0; i < 3; i++) begin
            exp_reg(12'h010 + 12'(i), 32'hA000_0000 + 32'(i), "R3");
            send(32'hA000_0000 + 32'(i));
            if (i == 0) idle(3);
        end
        drained("R3");

        // R4: non-incrementing run into the 2D set
        send(hdr1(16'd2, 12'h805, 1'b0));
        exp_reg(12'h805, 32'h1111_2222, "R4"); send(32'h1111_2222);
        exp_reg(12'h805, 32'h3333_4444, "R4"); send(32'h3333_4444);
        drained("R4");

        // R3: zero count consumes only the header
        send(hdr1(16'd0, 12'h123, 1'b1));
        j = 32'h0004_5018;
        exp_jmp(j, "R3");
        send(j);
        drained("R3");

        // R5/R6: masked write crossing into the 2D set, header-like pads
        send(hdr4(3'd2, 14'b00_0000_1010_0001, 12'h7FE));
        exp_reg(12'h7FE, 32'hB000_0000, "R5"); send(32'hB000_0000);
        idle(2);
        exp_reg(12'h803, 32'hB000_0005, "R5"); send(32'hB000_0005);
        exp_reg(12'h805, 32'hB000_0007, "R5"); send(32'hB000_0007);
        send(32'h0000_0018);
        idle(1);
        send(32'h0000_0006);
        j = 32'h0007_7018;
        exp_jmp(j, "R6");
        send(j);
        drained("R6");

        // R6: zero mask with one pad word
        send(hdr4(3'd1, 14'd0, 12'h040));
        send(32'h0000_0028);
        j = 32'h0000_8018;
        exp_jmp(j, "R6");
        send(j);
        drained("R6");

        // R5: highest mask bit only, no pad
        send(hdr4(3'd0, 14'h2000, 12'h100));
        exp_reg(12'h10D, 32'hC0DE_0001, "R5"); send(32'hC0DE_0001);
        drained("R5");

        // R7: frame buffer target
        send(hdr5(2'd2, 8'h00, 19'd3));
        send(32'hAB12_3458);
        for (int i = 0; i < 3; i++) begin
            exp_mem(1'b0, 22'((32'hAB12_3458 & 32'h00FF_FFFF) >> 2) + 22'(i), 32'hD000_0000 + 32'(i), "R7");
            send(32'hD000_0000 + 32'(i));
            if (i == 1) idle(2);
        end
        drained("R7");

        // R7: texture target
        send(hdr5(2'd3, 8'h00, 19'd2));
        send(32'h0000_0FFC);
        exp_mem(1'b1, 22'h3FF, 32'hE000_0001, "R7"); send(32'hE000_0001);
        exp_mem(1'b1, 22'h400, 32'hE000_0002, "R7"); send(32'hE000_0002);
        drained("R7");

        // R7: zero count consumes the address word only
        send(hdr5(2'd2, 8'h00, 19'd0));
        send(32'h0000_0018);
        j = 32'h0000_C018;
        exp_jmp(j, "R7");
        send(j);
        drained("R7");

        // R8: byte disables set
        exp_err("R8");
        send(hdr5(2'd2, 8'h01, 19'd2));
        send(32'h0000_1000);
        send(32'h0000_0018);
        send(32'h0000_0004);
        j = 32'h0001_0018;
        exp_jmp(j, "R8");
        send(j);
        drained("R8");

        // R8: unsupported target code
        exp_err("R8");
        send(hdr5(2'd1, 8'h00, 19'd1));
        send(32'h0000_2000);
        send(32'h0000_0018);
        j = 32'h0002_0018;
        exp_jmp(j, "R8");
        send(j);
        drained("R8");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule